// File: doc/BRIEF.md
# Three-Wire Control Bus Slave Port

This block is the device side of a three-wire host control bus with a mode line, a bit clock and a data line. A transfer begins with an address byte, shifted in while the mode line is low. The upper six bits of that byte select a device, and the lower two bits choose what the following data bytes mean. While the mode line is high, data bytes then write the local register file, read it back, load the register pointer, or return one status byte. A device that was not addressed stays silent until the host sends the next address byte.

The level of the mode line while reset is held decides which bus the port serves. A high level selects a two-wire bus. Its engine lives elsewhere, and in that case this port never arms. A low level selects the three-wire bus. After reset is released, the host must raise and then lower the mode line while the bit clock stays high. Only after that step does the port accept a transfer or drive the data line.

All bus lines are resynchronised to the system clock. Internal edge events drive a 16-byte register file. Each write is also reported on a strobe output, together with its address and data.

Top module: `tw3_ctrl_port`

## Requirements
- R1: The mode line level sampled while rst_n is low sets two_wire_sel: 1 for the two-wire bus, 0 for this bus. With two_wire_sel at 1, port_armed stays 0 and the port performs no transfer, even after a mode-line toggle.
- R2: After reset, port_armed is 0 until the mode line has gone high and then low with the bit clock high. While port_armed is 0, cb_oe stays 0, no reg_wr_stb pulse occurs and clocked bits are discarded.
- R3: Bits are shifted least significant bit first and are sampled on a rising bit-clock edge. A byte sent with the mode line low is an address byte. The port is selected only when bits 7..2 of that byte equal 6'b011000, so the valid address bytes are 0x60 to 0x63.
- R4: In sub-mode 00 (address byte bits 1..0), every data byte is written to register[ptr] and produces a one-cycle reg_wr_stb with reg_wr_addr = ptr and reg_wr_data = the byte. The pointer then increments modulo 16.
- R5: In sub-mode 01, every data byte period returns register[ptr], LSB first. Each bit is driven after a falling bit-clock edge and is valid at the following rising edge. The pointer then increments modulo 16.
- R6: In sub-mode 10, a data byte loads its bits 3..0 into the register pointer.
- R7: In sub-mode 11, the first data byte returns the value of status_in, captured at the start of the byte. Later bytes in the same data phase are not driven (cb_oe stays 0).
- R8: After an address byte whose bits 7..2 differ from 011000, mode-high bytes cause no write, no drive and no pointer change.
- R9: The sub-mode latched from an address byte applies to every data byte until the next address byte.
- R10: Reset sets the pointer to 0 and sets register i to ((19*i) mod 256) XOR 0xA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| cb_mode | input | 1 | Bus mode line (low: address, high: data) |
| cb_clk | input | 1 | Bus bit clock, idles high |
| cb_din | input | 1 | Bus data from host |
| cb_dout | output | 1 | Bus data to host |
| cb_oe | output | 1 | Drive enable for cb_dout |
| status_in | input | 8 | Status byte returned in sub-mode 11 |
| two_wire_sel | output | 1 | Bus type latched during reset |
| port_armed | output | 1 | Port has seen the post-reset mode toggle |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 4 | Register written |
| reg_wr_data | output | 8 | Byte written |

## Verification
Some properties are checked on every cycle. The port never drives the data line while unarmed or while the mode line is low. A write strobe occurs only when the port is selected in write sub-mode, and each write advances the pointer by one. The two-wire selection never arms the port, and a byte completes only on a rising bit-clock edge. Other behaviours can only be shown by the bench scenarios, which sweep every non-matching device ID, every register default, a wrapping write sweep and the single-status rule: the actual byte values shifted out LSB first, the pointer-load effect, the restoring of defaults on reset and sub-mode persistence.

// File: rtl/tw3_pkg.sv
package tw3_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SUB_WR  = 2'b00,
    SUB_RD  = 2'b01,
    SUB_PTR = 2'b10,
    SUB_ST  = 2'b11
  } sub_e;

  function automatic logic dev_match(input logic [BYTE_W-1:0] b, input logic [5:0] id);
    return b[BYTE_W-1:2] == id;
  endfunction

  function automatic sub_e sub_code(input logic [BYTE_W-1:0] b);
    return sub_e'(b[1:0]);
  endfunction

  function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
    logic [BYTE_W-1:0] prod;
    prod = BYTE_W'(idx * 19);
    return prod ^ 8'hA5;
  endfunction
endpackage

// File: rtl/tw3_sync.sv
module tw3_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) pipe[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) pipe[s] <= pipe[s-1];
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/tw3_arm.sv
module tw3_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_s,
  input  logic clk_s,
  output logic two_wire,
  output logic armed
);
  typedef enum logic [1:0] {WAIT_HI, WAIT_LO, READY} arm_e;
  arm_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      two_wire <= mode_s;
      state    <= WAIT_HI;
    end else if (!two_wire && clk_s) begin
      case (state)
        WAIT_HI: if (mode_s)  state <= WAIT_LO;
        WAIT_LO: if (!mode_s) state <= READY;
        default: state <= READY;
      endcase
    end
  end

  assign armed = (state == READY);

  a_r1_two_wire_idle: assert property (@(posedge clk) disable iff (!rst_n)
    two_wire |-> !armed);
endmodule

// File: rtl/tw3_shifter.sv
module tw3_shifter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rise,
  input  logic              din_s,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
    end else if (clear) begin
      bit_cnt   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= rise && (bit_cnt == CNT_W'(BYTE_W-1));
      if (rise) begin
        byte_val <= {din_s, byte_val[BYTE_W-1:1]};
        bit_cnt  <= (bit_cnt == CNT_W'(BYTE_W-1)) ? '0 : bit_cnt + 1'b1;
      end
    end
  end

  a_r3_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(rise));
endmodule

// File: rtl/tw3_regfile.sv
module tw3_regfile #(
  parameter int PTR_W  = 4,
  parameter int BYTE_W = 8,
  localparam int NREG  = 1 << PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= tw3_pkg::reg_default(i);
      else if (we && waddr == PTR_W'(i))
        regs[i] <= wdata;
    end
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/tw3_ctrl_port.sv
module tw3_ctrl_port #(
  parameter int         PTR_W       = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ID      = 6'b011000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cb_mode,
  input  logic       cb_clk,
  input  logic       cb_din,
  output logic       cb_dout,
  output logic       cb_oe,
  input  logic [7:0] status_in,
  output logic       two_wire_sel,
  output logic       port_armed,
  output logic       reg_wr_stb,
  output logic [3:0] reg_wr_addr,
  output logic [7:0] reg_wr_data
);
  import tw3_pkg::*;
  localparam int CNT_W = $clog2(BYTE_W);

  logic [2:0] sync_q;
  logic mode_s, clk_s, din_s;
  logic mode_d, clk_d;
  logic rise, fall, mode_edge;

  tw3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .d({cb_mode, cb_clk, cb_din}), .q(sync_q));
  assign {mode_s, clk_s, din_s} = sync_q;

  always_ff @(posedge clk) begin
    mode_d <= mode_s;
    clk_d  <= clk_s;
  end

  assign rise      = clk_s && !clk_d;
  assign fall      = !clk_s && clk_d;
  assign mode_edge = mode_s ^ mode_d;

  tw3_arm u_arm (
    .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .clk_s(clk_s),
    .two_wire(two_wire_sel), .armed(port_armed));

  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;

  tw3_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(!port_armed || mode_edge),
    .rise(rise), .din_s(din_s), .bit_cnt(bit_cnt),
    .byte_done(byte_done), .byte_val(byte_val));

  logic              sel_q;
  sub_e              sub_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              stat_done;
  logic [BYTE_W-1:0] tx_hold;
  logic              dout_q;
  logic [BYTE_W-1:0] rd_data;
  logic              addr_done, data_done, drive_phase;
  logic [BYTE_W-1:0] tx_src;

  assign addr_done   = byte_done && !mode_s;
  assign data_done   = byte_done && mode_s && sel_q;
  assign drive_phase = port_armed && mode_s && sel_q &&
                       (sub_q == SUB_RD || (sub_q == SUB_ST && !stat_done));
  assign tx_src      = (sub_q == SUB_RD) ? rd_data : status_in;
  assign reg_wr_stb  = data_done && sub_q == SUB_WR;

  tw3_regfile #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_wr_stb), .waddr(ptr_q),
    .wdata(byte_val), .raddr(ptr_q), .rdata(rd_data));

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      sub_q     <= SUB_WR;
      ptr_q     <= '0;
      stat_done <= 1'b0;
      tx_hold   <= '0;
      dout_q    <= 1'b0;
    end else begin
      if (addr_done) begin
        sel_q     <= dev_match(byte_val, DEV_ID);
        sub_q     <= sub_code(byte_val);
        stat_done <= 1'b0;
      end else if (data_done) begin
        case (sub_q)
          SUB_WR, SUB_RD: ptr_q     <= ptr_next(ptr_q);
          SUB_PTR:        ptr_q     <= byte_val[PTR_W-1:0];
          default:        stat_done <= 1'b1;
        endcase
      end
      if (fall && drive_phase) begin
        if (bit_cnt == '0) begin
          tx_hold <= tx_src;
          dout_q  <= tx_src[0];
        end else begin
          dout_q  <= tx_hold[bit_cnt];
        end
      end
    end
  end

  assign cb_oe       = drive_phase;
  assign cb_dout     = dout_q;
  assign reg_wr_addr = 4'(ptr_q);
  assign reg_wr_data = byte_val;

  a_r2_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !port_armed |-> !cb_oe);
  a_r5_drive_mode_high: assert property (@(posedge clk) disable iff (!rst_n)
    cb_oe |-> mode_s);
  a_r8_write_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |-> (sel_q && sub_q == SUB_WR && port_armed));
  a_r4_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |=> ptr_q == ptr_next($past(ptr_q)));
endmodule

// File: tb/tw3_ctrl_port_bench.sv
module tw3_ctrl_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cb_mode = 1'b0, cb_clk = 1'b1, cb_din = 1'b0;
  logic cb_dout, cb_oe;
  logic [7:0] status_in = 8'h00;
  logic two_wire_sel, port_armed, reg_wr_stb;
  logic [3:0] reg_wr_addr;
  logic [7:0] reg_wr_data;

  int total = 0, bad = 0;
  int wr_cnt = 0, oe_cnt = 0;
  logic [3:0] last_addr;
  logic [7:0] last_data;
  logic [7:0] mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  tw3_ctrl_port u_tw3_ctrl_port (
    .clk(clk), .rst_n(rst_n), .cb_mode(cb_mode), .cb_clk(cb_clk),
    .cb_din(cb_din), .cb_dout(cb_dout), .cb_oe(cb_oe),
    .status_in(status_in), .two_wire_sel(two_wire_sel),
    .port_armed(port_armed), .reg_wr_stb(reg_wr_stb),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data));

  always @(posedge clk) begin
    if (reg_wr_stb) begin
      wr_cnt    <= wr_cnt + 1;
      last_addr <= reg_wr_addr;
      last_data <= reg_wr_data;
    end
    if (cb_oe) oe_cnt <= oe_cnt + 1;
  end

  function automatic logic [7:0] dflt(input int i);
    return 8'(((19 * i) % 256) ^ 165);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic set_mode(input logic v);
    cb_mode = v;
    wait_h();
    wait_h();
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      cb_clk = 1'b0; cb_din = b[i]; wait_h();
      cb_clk = 1'b1; wait_h();
    end
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      cb_clk = 1'b0; wait_h();
      b[i] = cb_dout;
      cb_clk = 1'b1; wait_h();
    end
  endtask

  task automatic address(input logic [7:0] a);
    set_mode(1'b0);
    send_byte(a);
    set_mode(1'b1);
  endtask

  task automatic do_reset(input logic mode_lvl);
    cb_clk = 1'b1; cb_mode = mode_lvl; rst_n = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) mem[i] = dflt(i);
  endtask

  task automatic read_all_from0(input string req);
    logic [7:0] v;
    address(8'h62); send_byte(8'h00);
    address(8'h61);
    for (int i = 0; i < 16; i++) begin
      recv_byte(v);
      check(v == mem[i], req, v, mem[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int w0, o0;
    // R1 / R2 reset state
    do_reset(1'b0);
    check(two_wire_sel == 1'b0, "R1 three-wire select", two_wire_sel, 0);
    check(port_armed == 1'b0, "R2 unarmed after reset", port_armed, 0);
    check(cb_oe == 1'b0, "R2 no drive after reset", cb_oe, 0);

    // R2: traffic before arming is discarded
    send_byte(8'h60);
    cb_mode = 1'b1; wait_h(); wait_h();
    send_byte(8'h11);
    check(wr_cnt == 0, "R2 no write while unarmed", wr_cnt, 0);
    check(oe_cnt == 0, "R2 no drive while unarmed", oe_cnt, 0);
    set_mode(1'b0);
    check(port_armed == 1'b1, "R2 armed after toggle", port_armed, 1);

    // R10 / R5 / R6: defaults read back LSB first
    read_all_from0("R10 default value");

    // R4 / R9: write sweep from pointer 3, wrapping past 15
    address(8'h62); send_byte(8'h03);
    address(8'h60);
    for (int i = 0; i < 16; i++) begin
      v = 8'(i * 37 + 11);
      send_byte(v);
      mem[(3 + i) % 16] = v;
    end
    repeat (2) @(negedge clk);
    check(wr_cnt == 16, "R9 sub-mode kept for all bytes", wr_cnt, 16);
    check(last_addr == 4'd2, "R4 pointer wrap", last_addr, 2);
    check(last_data == 8'(15 * 37 + 11), "R4 write data", last_data, 8'(15 * 37 + 11));
    read_all_from0("R5 read back written");

    // R6: pointer load then single read
    address(8'h62); send_byte(8'hF9);
    address(8'h61); recv_byte(v);
    check(v == mem[9], "R6 pointer load low bits", v, mem[9]);

    // R8 / R3: every non-matching device ID is ignored
    address(8'h62); send_byte(8'h05);
    w0 = wr_cnt;
    for (int id = 0; id < 64; id++) begin
      if (id != 24) begin
        address({6'(id), 2'b00}); send_byte(8'hFF);
        o0 = oe_cnt;
        address({6'(id), 2'b01}); recv_byte(v);
        check(oe_cnt == o0, "R8 no drive for foreign ID", oe_cnt, o0);
      end
    end
    check(wr_cnt == w0, "R8 no write for foreign ID", wr_cnt, w0);
    address(8'h61); recv_byte(v);
    check(v == mem[5], "R3 pointer unchanged by foreign ID", v, mem[5]);

    // R7: one status byte, then silence
    status_in = 8'hC3;
    address(8'h63); recv_byte(v);
    check(v == 8'hC3, "R7 status byte", v, 8'hC3);
    o0 = oe_cnt;
    recv_byte(v);
    check(oe_cnt == o0, "R7 second status byte not driven", oe_cnt, o0);

    // R10: hard reset restores defaults
    do_reset(1'b0);
    set_mode(1'b1); set_mode(1'b0);
    read_all_from0("R10 defaults after reset");

    // R1: two-wire selection never arms
    do_reset(1'b1);
    check(two_wire_sel == 1'b1, "R1 two-wire select", two_wire_sel, 1);
    set_mode(1'b0); set_mode(1'b1); set_mode(1'b0);
    check(port_armed == 1'b0, "R1 two-wire stays unarmed", port_armed, 0);
    w0 = wr_cnt;
    address(8'h60); send_byte(8'h77);
    repeat (2) @(negedge clk);
    check(wr_cnt == w0, "R1 no write in two-wire", wr_cnt, w0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule